// File: doc/BRIEF.md
# Dual-Mode Digital Phase Comparator

This block compares a reference input against a feedback input and produces a phase-error drive for a digital loop. Both inputs are sampled by a fast system clock. Each passes through a synchronizer and a rising-edge detector before it reaches the comparators. A mode input chooses which of two comparators drives the output, and the selection takes effect in the same cycle.

The level comparator marks every cycle in which the synchronized inputs differ. Its average output follows the phase offset between the inputs, and it only reaches its full range when both inputs are square waves. The edge comparator reacts only to rising edges. A reference edge arms an "up" flag and a feedback edge arms a "down" flag. When both flags are armed they clear each other, so the drive pulse lasts as long as the timing gap between the two edges. When no drive is needed, the output rests in an idle code that stands for a released, high-impedance charge pump.

The drive is given as a 2-bit code and also as a signed error value that a loop filter can accumulate directly.

Top module: `dual_phase_cmp`

## Requirements
- R1: While reset is asserted and right after it is released with no input activity, the edge mode gives code 00 and error 0, and the level mode gives code 10.
- R2: In level mode (mode_pfd = 0) the code is 01 when the synchronized reference and feedback levels differ and 10 when they are equal. A raw input change reaches the code on the third rising clock edge after it.
- R3: In level mode the code is never 00. For two square waves of equal period offset by a quarter period, the code is 01 for exactly half of the cycles.
- R4: In edge mode (mode_pfd = 1), a reference rising edge that leads the feedback rising edge by N cycles gives code 01 (up) for exactly N cycles, followed by 00.
- R5: In edge mode, a feedback rising edge that leads the reference rising edge by N cycles gives code 10 (down) for exactly N cycles, followed by 00.
- R6: Rising edges that arrive on both inputs in the same cycle produce no up or down cycle.
- R7: Falling edges have no effect in edge mode. The pulse width does not depend on how long either input stays high, and falling edges alone leave the code at 00.
- R8: In edge mode, a reference at a higher frequency than the feedback gives up for most cycles and never down. The opposite case gives down for most cycles and never up.
- R9: With feedback edges and no reference edges, edge mode holds down in every cycle from the first feedback edge onward.
- R10: The code 11 never appears. The up and down flags are never both set for two consecutive cycles.
- R11: err_code is +1 for up (01), -1 for down (10) and 0 for idle (00), sign-extended to ERR_W bits.
- R12: A change of mode_pfd changes the code within the same cycle, because both comparators keep running whichever one is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pfd | input | 1 | 0 = level (exclusive-OR) comparator, 1 = edge comparator |
| ref_in | input | 1 | Raw reference input |
| fb_in | input | 1 | Raw feedback input |
| drive_code | output | 2 | 01 up, 10 down, 00 idle |
| err_code | output | ERR_W | Signed error: +1, -1 or 0 |

## Verification
The two functions that can fall in one cycle are the arming of the up flag and the arming of the down flag. They meet when rising edges on both inputs coincide, and also when a late edge arrives while the opposite flag is still armed. Coinciding edges are provoked by raising both raw inputs at the same negative clock edge. Lead and lag cases are provoked by spacing the edges N cycles apart. The judgement is made by counting up, down and idle cycles across the whole window: an exact count of N, or zero, must appear, and the code 11 must never be seen.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   typedef enum logic [1:0] {
      DRV_IDLE = 2'b00,
      DRV_UP   = 2'b01,
      DRV_DOWN = 2'b10
   } drive_t;
endpackage

// File: rtl/dpc_edge_sync.sv
module dpc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   localparam int CHAIN_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dpc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], din};
   end

   assign level = chain_q[STAGES-1];
   assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R7: a rising-edge pulse never lasts more than one cycle
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/dpc_xor_det.sv
module dpc_xor_det (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_lvl,
   input  logic fb_lvl,
   output logic diff_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) diff_q <= 1'b0;
      else        diff_q <= ref_lvl ^ fb_lvl;
   end

   // R2: equal levels give a low result on the next cycle
   assert_equal_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_lvl == fb_lvl) |=> !diff_q);
endmodule

// File: rtl/dpc_pfd.sv
module dpc_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_rise,
   input  logic fb_rise,
   output logic up_q,
   output logic dn_q
);
   logic clr;
   logic up_n;
   logic dn_n;

   assign clr  = up_q & dn_q;
   assign up_n = (up_q & ~clr) | ref_rise;
   assign dn_n = (dn_q & ~clr) | fb_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_n;
         dn_q <= dn_n;
      end
   end

   // R10: the two flags are never both set for two cycles in a row
   assert_one_cycle_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q) |=> !(up_q && dn_q));
   // R4: a lone reference edge always arms up
   assert_ref_arms_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_rise && !fb_rise) |=> up_q);
   // R9: without reference edges an armed down flag stays armed
   assert_down_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_q && !up_q && !ref_rise) |=> dn_q);
endmodule

// File: rtl/dual_phase_cmp.sv
module dual_phase_cmp #(
   parameter int SYNC_STAGES = 2,
   parameter int ERR_W       = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_pfd,
   input  logic                    ref_in,
   input  logic                    fb_in,
   output logic [1:0]              drive_code,
   output logic signed [ERR_W-1:0] err_code
);
   import dpc_pkg::*;

   localparam logic signed [ERR_W-1:0] ERR_POS = ERR_W'(1);
   localparam logic signed [ERR_W-1:0] ERR_NEG = -ERR_W'(1);

   generate
      if (ERR_W < 2) begin : g_bad_err_w
         $error("dual_phase_cmp: ERR_W must be at least 2");
      end
   endgenerate

   logic ref_lvl, ref_rise, fb_lvl, fb_rise;
   logic diff_q, up_q, dn_q;
   drive_t xor_drv, pfd_drv, sel_drv;

   dpc_edge_sync #(.STAGES(SYNC_STAGES)) ref_sync_i (
      .clk(clk), .rst_n(rst_n), .din(ref_in), .level(ref_lvl), .rise(ref_rise));
   dpc_edge_sync #(.STAGES(SYNC_STAGES)) fb_sync_i (
      .clk(clk), .rst_n(rst_n), .din(fb_in), .level(fb_lvl), .rise(fb_rise));

   dpc_xor_det xor_i (
      .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .fb_lvl(fb_lvl), .diff_q(diff_q));

   dpc_pfd pfd_i (
      .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
      .up_q(up_q), .dn_q(dn_q));

   always_comb begin
      xor_drv = diff_q ? DRV_UP : DRV_DOWN;
      if (up_q && !dn_q)      pfd_drv = DRV_UP;
      else if (dn_q && !up_q) pfd_drv = DRV_DOWN;
      else                    pfd_drv = DRV_IDLE;
      sel_drv = mode_pfd ? pfd_drv : xor_drv;
   end

   assign drive_code = sel_drv;

   always_comb begin
      case (sel_drv)
         DRV_UP:   err_code = ERR_POS;
         DRV_DOWN: err_code = ERR_NEG;
         default:  err_code = '0;
      endcase
   end

   // R10: the reserved code never leaves the block
   assert_no_code11_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drive_code != 2'b11);
   // R3: level mode never reports idle
   assert_xor_never_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_pfd |-> drive_code != 2'b00);
   // R11: the sign of the error agrees with the drive code
   assert_err_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_code == 2'b10) |-> (err_code < 0));
   assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_code == 2'b00) |-> (err_code == 0));
endmodule

// File: tb/dual_phase_cmp_tb_top.sv
module dual_phase_cmp_tb_top;
   localparam int ERR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_pfd = 1'b1;
   logic ref_in = 1'b0;
   logic fb_in = 1'b0;
   logic [1:0] drive_code;
   logic signed [ERR_W-1:0] err_code;

   int checks = 0;
   int failures = 0;
   bit seen11 = 1'b0;

   always #10 clk = ~clk;

   dual_phase_cmp #(.SYNC_STAGES(2), .ERR_W(ERR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_pfd(mode_pfd), .ref_in(ref_in),
      .fb_in(fb_in), .drive_code(drive_code), .err_code(err_code));

   always @(negedge clk) if (rst_n && drive_code == 2'b11) seen11 = 1'b1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_true(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit m);
      ref_in = 1'b0;
      fb_in = 1'b0;
      mode_pfd = m;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one edge-mode scenario: rising edges at set cycles, optional early fall of ref
   task automatic pfd_run(input int ref_at, input int fb_at, input int ref_fall,
                          input int total, output int ups, output int dns);
      ups = 0;
      dns = 0;
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         if (drive_code == 2'b01) ups++;
         if (drive_code == 2'b10) dns++;
         if (i == ref_at) ref_in = 1'b1;
         if (i == fb_at) fb_in = 1'b1;
         if (i == ref_fall) ref_in = 1'b0;
      end
   endtask

   task automatic test_reset;
      do_reset(1'b1);
      @(negedge clk);
      chk("R1 pfd reset code", drive_code, 0);
      chk("R1 pfd reset err", int'(err_code), 0);
      do_reset(1'b0);
      @(negedge clk);
      chk("R1 xor reset code", drive_code, 2);
   endtask

   task automatic test_xor_latency;
      do_reset(1'b0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 2) chk("R2 xor before latency", drive_code, 2);
         if (i == 3) chk("R2 xor differ", drive_code, 1);
         if (i == 3) chk("R11 err up", int'(err_code), 1);
         if (i == 6) chk("R2 xor equal again", drive_code, 2);
         if (i == 0) ref_in = 1'b1;
         if (i == 3) fb_in = 1'b1;
      end
   endtask

   task automatic test_xor_quadrature;
      int ups = 0;
      int idles = 0;
      do_reset(1'b0);
      for (int t = 0; t < 96; t++) begin
         @(negedge clk);
         if (t >= 32) begin
            if (drive_code == 2'b01) ups++;
            if (drive_code == 2'b00) idles++;
         end
         ref_in = ((t % 8) < 4);
         fb_in = (((t + 6) % 8) < 4);
      end
      chk("R3 xor quadrature up count", ups, 32);
      chk("R3 xor idle count", idles, 0);
   endtask

   task automatic test_lead;
      int u, d;
      do_reset(1'b1);
      pfd_run(2, 6, -1, 20, u, d);
      chk("R4 lead up count", u, 4);
      chk("R4 lead down count", d, 0);
      chk("R4 idle after pulse", drive_code, 0);
   endtask

   task automatic test_lag;
      int u, d;
      do_reset(1'b1);
      pfd_run(7, 2, -1, 20, u, d);
      chk("R5 lag down count", d, 5);
      chk("R5 lag up count", u, 0);
      chk("R11 idle err", int'(err_code), 0);
   endtask

   task automatic test_simul;
      int u, d;
      do_reset(1'b1);
      pfd_run(3, 3, -1, 16, u, d);
      chk("R6 simultaneous up", u, 0);
      chk("R6 simultaneous down", d, 0);
   endtask

   task automatic test_duty;
      int u, d;
      do_reset(1'b1);
      pfd_run(2, 8, 3, 20, u, d);
      chk("R7 short duty up count", u, 6);
      do_reset(1'b1);
      ref_in = 1'b1;
      fb_in = 1'b1;
      repeat (10) @(negedge clk);
      // both flags are now cleared; falling edges only follow
      pfd_run(-1, -1, -1, 1, u, d);
      ref_in = 1'b0;
      pfd_run(-1, -1, -1, 4, u, d);
      fb_in = 1'b0;
      pfd_run(-1, -1, -1, 8, u, d);
      chk("R7 falling edges up", u, 0);
      chk("R7 falling edges down", d, 0);
   endtask

   task automatic test_freq(input bit ref_fast);
      int u = 0;
      int d = 0;
      do_reset(1'b1);
      for (int t = 0; t < 90; t++) begin
         @(negedge clk);
         if (drive_code == 2'b01) u++;
         if (drive_code == 2'b10) d++;
         ref_in = ref_fast ? ((t % 4) < 2) : ((t % 10) < 5);
         fb_in = ref_fast ? ((t % 10) < 5) : ((t % 4) < 2);
      end
      if (ref_fast) begin
         chk_true("R8 fast ref mostly up", u >= 45, u, 45);
         chk("R8 fast ref no down", d, 0);
      end else begin
         chk_true("R8 slow ref mostly down", d >= 45, d, 45);
         chk("R8 slow ref no up", u, 0);
      end
   endtask

   task automatic test_no_ref;
      int u = 0;
      int d = 0;
      do_reset(1'b1);
      for (int t = 0; t < 60; t++) begin
         @(negedge clk);
         if (drive_code == 2'b01) u++;
         if (drive_code == 2'b10) d++;
         fb_in = ((t % 6) < 3);
      end
      chk("R9 no ref down count", d, 57);
      chk("R9 no ref up count", u, 0);
      chk("R11 down err", int'(err_code), -1);
   endtask

   task automatic test_mode_switch;
      do_reset(1'b1);
      fb_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R12 pfd down held", drive_code, 2);
      mode_pfd = 1'b0;
      #1;
      chk("R12 switch to xor", drive_code, 1);
      @(negedge clk);
      mode_pfd = 1'b1;
      #1;
      chk("R12 switch back to pfd", drive_code, 2);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      test_reset();
      test_xor_latency();
      test_xor_quadrature();
      test_lead();
      test_lag();
      test_simul();
      test_duty();
      test_freq(1'b1);
      test_freq(1'b0);
      test_no_ref();
      test_mode_switch();
      chk("R10 code 11 seen", int'(seen11), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule